// File: doc/BRIEF.md
# Flat or Two-Level Table Entry Fetcher

This block looks up one 64-bit entry of an in-memory table, given an index such as a device number or a collection number. The table is laid out in one of two ways. In the flat layout the entry sits directly at an offset from the table base. In the two-level layout the base points at an array of 8-byte descriptors. Each descriptor names a second-level page that holds the entries.

A lookup starts with a one-cycle `start` pulse. The block latches the index and the configuration: base, page size code, entry size and the layout flag. It then issues one or two 64-bit little-endian reads on a simple request/response memory port and finishes with a one-cycle `done` pulse. Along with `done` it returns the entry, a valid flag taken from the entry's top bit, and an error flag. The walk stops after the first read when the descriptor is not valid or the read fails. Page sizes are limited to powers of two, and so are entry sizes, so every division and modulo reduces to a shift or a mask.

Top module: `table_walker`

## Requirements
- R1: In flat mode (`cfg_indirect`=0) exactly one read is issued, at `cfg_base + index * 2^cfg_esz_log2`.
- R2: In two-level mode the first read fetches the descriptor at `cfg_base + (index >> (P-3)) * 8`, where 2^P is the page size in bytes.
- R3: The second-level page base is bits [50:0] of the descriptor; bits [62:51] play no part in any address.
- R4: The second read is at `l2_base + (index mod 2^(P-cfg_esz_log2)) * 2^cfg_esz_log2`.
- R5: On a lookup that completes without error, `entry` is the last word read and `entry_valid` equals its bit 63.
- R6: A descriptor whose bit 63 is clear ends the walk after one read, with `entry`=0, `entry_valid`=0 and `entry_err`=0.
- R7: A response with `mem_rsp_err`=1 on either read ends the lookup at once, with no further read, `entry_err`=1, `entry_valid`=0 and `entry`=0.
- R8: `cfg_page_sel` encodes the page size as 0 = 4 KiB, 1 = 16 KiB, 2 = 64 KiB, and 3 is treated as 64 KiB. The entry size is 2^`cfg_esz_log2` bytes, with `cfg_esz_log2` from 3 to 6.
- R9: While `busy` is high, `start` is ignored, and changes on the configuration and index inputs do not affect the lookup in progress.
- R10: `mem_req` and `done` are single-cycle pulses. The result outputs hold their value until the next lookup completes.
- R11: After reset, `busy`, `mem_req`, `done`, `entry_valid`, `entry_err` and `entry` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a lookup (taken only when idle) |
| cfg_indirect | input | 1 | 1 = two-level table, 0 = flat |
| cfg_page_sel | input | 2 | Page size code (see R8) |
| cfg_esz_log2 | input | 3 | log2 of entry size in bytes |
| cfg_base | input | ADDR_W | Table base byte address |
| lookup_idx | input | IDX_W | Index to look up |
| busy | output | 1 | Lookup in progress |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | ADDR_W | Byte address of the 64-bit read |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_data | input | 64 | Read data, little-endian word |
| mem_rsp_err | input | 1 | Read failed |
| done | output | 1 | Lookup finished pulse |
| entry | output | 64 | Fetched entry |
| entry_valid | output | 1 | Entry valid flag |
| entry_err | output | 1 | Lookup ended on a memory error |

## Verification
The hardest case to reach is a failed descriptor read whose data word still has its valid bit set. If the error were not given priority, the walk would go on to a second read. The bench's memory model returns a word with a valid descriptor at a chosen error address and flags the response as failed, then counts the reads after `done` to prove that no second one follows. A second hard case is a fresh `start` together with new configuration during a slow walk. It is reached by stretching the memory latency and driving the new values while `busy` is high.

// File: rtl/twl_pkg.sv
package twl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_L1   = 2'd1,
    ST_ENT  = 2'd2
  } walk_st_t;

  localparam int DESC_LOG2    = 3;
  localparam int L2_BASE_BITS = 51;
  localparam int VALID_BIT    = 63;

  function automatic logic [4:0] page_log2(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5'd12;
      2'd1:    return 5'd14;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/twl_addr_gen.sv
module twl_addr_gen #(
  parameter int ADDR_W = 52,
  parameter int IDX_W  = 20
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  input  logic [1:0]        psel,
  input  logic [2:0]        esz,
  input  logic [63:0]       desc,
  output logic [ADDR_W-1:0] flat_addr,
  output logic [ADDR_W-1:0] l1_addr,
  output logic [ADDR_W-1:0] l2_addr
);
  import twl_pkg::*;

  logic [63:0] base_x;
  logic [63:0] idx_x;
  logic [63:0] l2b_x;
  logic [63:0] mask;
  logic [63:0] flat_x;
  logic [63:0] l1_x;
  logic [63:0] l2_x;
  logic [4:0]  plog;
  logic [5:0]  l1_sh;
  logic [5:0]  epp;

  generate
    if (ADDR_W < 64) begin : g_base_pad
      assign base_x = {{(64-ADDR_W){1'b0}}, base};
    end else begin : g_base_full
      assign base_x = base;
    end
    if (IDX_W < 64) begin : g_idx_pad
      assign idx_x = {{(64-IDX_W){1'b0}}, idx};
    end else begin : g_idx_full
      assign idx_x = idx;
    end
  endgenerate

  assign l2b_x = {{(64-L2_BASE_BITS){1'b0}}, desc[L2_BASE_BITS-1:0]};

  always_comb begin
    plog   = page_log2(psel);
    l1_sh  = {1'b0, plog} - 6'(DESC_LOG2);
    epp    = {1'b0, plog} - {3'b000, esz};
    mask   = (64'd1 << epp) - 64'd1;
    flat_x = base_x + (idx_x << esz);
    l1_x   = base_x + ((idx_x >> l1_sh) << DESC_LOG2);
    l2_x   = l2b_x + ((idx_x & mask) << esz);
  end

  assign flat_addr = flat_x[ADDR_W-1:0];
  assign l1_addr   = l1_x[ADDR_W-1:0];
  assign l2_addr   = l2_x[ADDR_W-1:0];

endmodule

// File: rtl/twl_ctrl.sv
module twl_ctrl #(
  parameter int ADDR_W = 52,
  parameter int IDX_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cfg_indirect,
  input  logic [1:0]        cfg_page_sel,
  input  logic [2:0]        cfg_esz_log2,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [IDX_W-1:0]  lookup_idx,
  input  logic              rsp_valid,
  input  logic [63:0]       rsp_data,
  input  logic              rsp_err,
  input  logic [ADDR_W-1:0] flat_addr,
  input  logic [ADDR_W-1:0] l1_addr,
  input  logic [ADDR_W-1:0] l2_addr,
  output twl_pkg::walk_st_t st,
  output logic              busy,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] sel_base,
  output logic [IDX_W-1:0]  sel_idx,
  output logic [1:0]        sel_psel,
  output logic [2:0]        sel_esz,
  output logic              fin,
  output logic [63:0]       fin_entry,
  output logic              fin_valid,
  output logic              fin_err
);
  import twl_pkg::*;

  logic              cap_ind;
  logic [1:0]        cap_psel;
  logic [2:0]        cap_esz;
  logic [ADDR_W-1:0] cap_base;
  logic [IDX_W-1:0]  cap_idx;
  logic              idle;
  logic              desc_ok;

  assign idle     = (st == ST_IDLE);
  assign busy     = !idle;
  assign sel_base = idle ? cfg_base     : cap_base;
  assign sel_idx  = idle ? lookup_idx   : cap_idx;
  assign sel_psel = idle ? cfg_page_sel : cap_psel;
  assign sel_esz  = idle ? cfg_esz_log2 : cap_esz;
  assign desc_ok  = !rsp_err && rsp_data[VALID_BIT];

  always_comb begin
    fin       = 1'b0;
    fin_valid = 1'b0;
    fin_err   = 1'b0;
    fin_entry = 64'd0;
    if (rsp_valid) begin
      if (st == ST_ENT) begin
        fin       = 1'b1;
        fin_err   = rsp_err;
        fin_valid = !rsp_err && rsp_data[VALID_BIT];
        fin_entry = rsp_err ? 64'd0 : rsp_data;
      end else if (st == ST_L1 && !desc_ok) begin
        fin     = 1'b1;
        fin_err = rsp_err;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      cap_ind  <= 1'b0;
      cap_psel <= '0;
      cap_esz  <= '0;
      cap_base <= '0;
      cap_idx  <= '0;
    end else begin
      mem_req <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            cap_ind  <= cfg_indirect;
            cap_psel <= cfg_page_sel;
            cap_esz  <= cfg_esz_log2;
            cap_base <= cfg_base;
            cap_idx  <= lookup_idx;
            mem_req  <= 1'b1;
            mem_addr <= cfg_indirect ? l1_addr : flat_addr;
            st       <= cfg_indirect ? ST_L1 : ST_ENT;
          end
        end
        ST_L1: begin
          if (rsp_valid) begin
            if (desc_ok) begin
              mem_req  <= 1'b1;
              mem_addr <= l2_addr;
              st       <= ST_ENT;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_ENT: begin
          if (rsp_valid) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/twl_result.sv
module twl_result (
  input  logic        clk,
  input  logic        rst,
  input  logic        fin,
  input  logic [63:0] fin_entry,
  input  logic        fin_valid,
  input  logic        fin_err,
  output logic        done,
  output logic [63:0] entry,
  output logic        entry_valid,
  output logic        entry_err
);

  always_ff @(posedge clk) begin
    if (rst) begin
      done        <= 1'b0;
      entry       <= 64'd0;
      entry_valid <= 1'b0;
      entry_err   <= 1'b0;
    end else begin
      done <= fin;
      if (fin) begin
        entry       <= fin_entry;
        entry_valid <= fin_valid;
        entry_err   <= fin_err;
      end
    end
  end

endmodule

// File: rtl/table_walker.sv
module table_walker #(
  parameter int ADDR_W = 52,
  parameter int IDX_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cfg_indirect,
  input  logic [1:0]        cfg_page_sel,
  input  logic [2:0]        cfg_esz_log2,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [IDX_W-1:0]  lookup_idx,
  output logic              busy,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              done,
  output logic [63:0]       entry,
  output logic              entry_valid,
  output logic              entry_err
);
  import twl_pkg::*;

  walk_st_t          st;
  logic [ADDR_W-1:0] flat_addr;
  logic [ADDR_W-1:0] l1_addr;
  logic [ADDR_W-1:0] l2_addr;
  logic [ADDR_W-1:0] sel_base;
  logic [IDX_W-1:0]  sel_idx;
  logic [1:0]        sel_psel;
  logic [2:0]        sel_esz;
  logic              fin;
  logic [63:0]       fin_entry;
  logic              fin_valid;
  logic              fin_err;

  twl_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
    .base      (sel_base),
    .idx       (sel_idx),
    .psel      (sel_psel),
    .esz       (sel_esz),
    .desc      (mem_rsp_data),
    .flat_addr (flat_addr),
    .l1_addr   (l1_addr),
    .l2_addr   (l2_addr)
  );

  twl_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .cfg_indirect (cfg_indirect),
    .cfg_page_sel (cfg_page_sel),
    .cfg_esz_log2 (cfg_esz_log2),
    .cfg_base     (cfg_base),
    .lookup_idx   (lookup_idx),
    .rsp_valid    (mem_rsp_valid),
    .rsp_data     (mem_rsp_data),
    .rsp_err      (mem_rsp_err),
    .flat_addr    (flat_addr),
    .l1_addr      (l1_addr),
    .l2_addr      (l2_addr),
    .st           (st),
    .busy         (busy),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .sel_base     (sel_base),
    .sel_idx      (sel_idx),
    .sel_psel     (sel_psel),
    .sel_esz      (sel_esz),
    .fin          (fin),
    .fin_entry    (fin_entry),
    .fin_valid    (fin_valid),
    .fin_err      (fin_err)
  );

  twl_result u_res (
    .clk         (clk),
    .rst         (rst),
    .fin         (fin),
    .fin_entry   (fin_entry),
    .fin_valid   (fin_valid),
    .fin_err     (fin_err),
    .done        (done),
    .entry       (entry),
    .entry_valid (entry_valid),
    .entry_err   (entry_err)
  );

endmodule

// File: rtl/twl_checker.sv
module twl_checker (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_rsp_valid,
  input logic              mem_rsp_err,
  input logic [63:0]       mem_rsp_data,
  input logic              done,
  input logic [63:0]       entry,
  input logic              entry_valid,
  input logic              entry_err,
  input twl_pkg::walk_st_t st
);
  import twl_pkg::*;

  p_req_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_start_taken_r9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && mem_req));

  p_l2_follows_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_L1 && mem_rsp_valid && !mem_rsp_err && mem_rsp_data[63])
      |=> (mem_req && st == ST_ENT));

  p_no_l2_read_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_L1 && mem_rsp_valid && !mem_rsp_err && !mem_rsp_data[63])
      |=> (!mem_req && done && !entry_valid && !entry_err));

  p_err_stops_r7: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE && mem_rsp_valid && mem_rsp_err)
      |=> (!mem_req && !busy && done && entry_err && !entry_valid));

  p_valid_bit_r5: assert property (@(posedge clk) disable iff (rst)
    (done && !entry_err) |-> (entry_valid == entry[63]));

endmodule

bind table_walker twl_checker u_chk (
  .clk           (clk),
  .rst           (rst),
  .start         (start),
  .busy          (busy),
  .mem_req       (mem_req),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_err   (mem_rsp_err),
  .mem_rsp_data  (mem_rsp_data),
  .done          (done),
  .entry         (entry),
  .entry_valid   (entry_valid),
  .entry_err     (entry_err),
  .st            (st)
);

// File: tb/table_walker_tb.sv
module table_walker_tb;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 52;
  localparam int IDX_W  = 20;
  localparam int NV     = 14;

  typedef struct packed {
    logic              ind;
    logic [1:0]        psel;
    logic [2:0]        esz;
    logic [ADDR_W-1:0] base;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] erra;
    logic [1:0]        nrd;
    logic [ADDR_W-1:0] a1;
    logic [ADDR_W-1:0] a2;
    logic              ev;
    logic              ee;
    logic [63:0]       ent;
  } vec_t;

  // ind psel esz base idx erra nrd a1 a2 ev ee entry
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 3'd3, 52'h10000, 20'h5,     52'h0,     2'd1, 52'h10028, 52'h0,     1'b1, 1'b0, 64'h8000_0000_0000_00A5},
    '{1'b0, 2'd0, 3'd4, 52'h10000, 20'h3,     52'h0,     2'd1, 52'h10030, 52'h0,     1'b0, 1'b0, 64'h0000_0000_0000_0033},
    '{1'b0, 2'd0, 3'd6, 52'h10000, 20'h2,     52'h0,     2'd1, 52'h10080, 52'h0,     1'b1, 1'b0, 64'h8000_0000_0000_0C40},
    '{1'b1, 2'd0, 3'd3, 52'h10000, 20'h605,   52'h0,     2'd2, 52'h10018, 52'h40028, 1'b1, 1'b0, 64'h8000_0000_0000_1234},
    '{1'b1, 2'd1, 3'd4, 52'h20000, 20'h1803,  52'h0,     2'd2, 52'h20018, 52'h50030, 1'b1, 1'b0, 64'h8000_0000_0000_BEEF},
    '{1'b1, 2'd2, 3'd3, 52'h30000, 20'h2001,  52'h0,     2'd1, 52'h30008, 52'h0,     1'b0, 1'b0, 64'h0},
    '{1'b1, 2'd2, 3'd3, 52'h30000, 20'h4002,  52'h0,     2'd2, 52'h30010, 52'h70010, 1'b1, 1'b0, 64'h8000_0000_0000_0777},
    '{1'b1, 2'd3, 3'd5, 52'h30000, 20'h4005,  52'h0,     2'd2, 52'h30010, 52'h700A0, 1'b0, 1'b0, 64'h0000_0000_0000_00AA},
    '{1'b0, 2'd0, 3'd3, 52'h10000, 20'h9,     52'h10048, 2'd1, 52'h10048, 52'h0,     1'b0, 1'b1, 64'h0},
    '{1'b1, 2'd1, 3'd4, 52'h20000, 20'h1803,  52'h20018, 2'd1, 52'h20018, 52'h0,     1'b0, 1'b1, 64'h0},
    '{1'b1, 2'd1, 3'd4, 52'h20000, 20'h1803,  52'h50030, 2'd2, 52'h20018, 52'h50030, 1'b0, 1'b1, 64'h0},
    '{1'b1, 2'd0, 3'd6, 52'h10000, 20'h605,   52'h0,     2'd2, 52'h10018, 52'h40140, 1'b1, 1'b0, 64'h8000_0000_0000_5140},
    '{1'b1, 2'd1, 3'd3, 52'h20000, 20'h0,     52'h0,     2'd2, 52'h20000, 52'h80000, 1'b1, 1'b0, 64'h8000_0000_0000_0001},
    '{1'b0, 2'd0, 3'd3, 52'h100000, 20'hFFFFF, 52'h0,    2'd1, 52'h8FFFF8, 52'h0,    1'b1, 1'b0, 64'h8000_0000_00FF_FFFF}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              cfg_indirect = 1'b0;
  logic [1:0]        cfg_page_sel = '0;
  logic [2:0]        cfg_esz_log2 = 3'd3;
  logic [ADDR_W-1:0] cfg_base = '0;
  logic [IDX_W-1:0]  lookup_idx = '0;
  logic              busy;
  logic              mem_req;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_rsp_valid = 1'b0;
  logic [63:0]       mem_rsp_data = '0;
  logic              mem_rsp_err = 1'b0;
  logic              done;
  logic [63:0]       entry;
  logic              entry_valid;
  logic              entry_err;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [63:0]       mem [logic [ADDR_W-1:0]];
  logic [ADDR_W-1:0] err_addr = '0;
  int                lat = 1;
  int                pend_cnt = 0;
  logic [ADDR_W-1:0] pend_addr = '0;
  int                nreads = 0;
  logic [ADDR_W-1:0] addr1 = '0;
  logic [ADDR_W-1:0] addr2 = '0;

  table_walker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dut (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .cfg_indirect  (cfg_indirect),
    .cfg_page_sel  (cfg_page_sel),
    .cfg_esz_log2  (cfg_esz_log2),
    .cfg_base      (cfg_base),
    .lookup_idx    (lookup_idx),
    .busy          (busy),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .mem_rsp_err   (mem_rsp_err),
    .done          (done),
    .entry         (entry),
    .entry_valid   (entry_valid),
    .entry_err     (entry_err)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [63:0] rd(input logic [ADDR_W-1:0] a);
    if (mem.exists(a)) return mem[a];
    return 64'd0;
  endfunction

  // memory model: sees requests and answers at the falling edge
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    mem_rsp_err   = 1'b0;
    if (pend_cnt > 0) begin
      pend_cnt = pend_cnt - 1;
      if (pend_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rd(pend_addr);
        mem_rsp_err   = (pend_addr == err_addr);
      end
    end
    if (mem_req) begin
      nreads = nreads + 1;
      if (nreads == 1) addr1 = mem_addr;
      if (nreads == 2) addr2 = mem_addr;
      pend_addr = mem_addr;
      pend_cnt  = lat;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_done(output bit ok);
    int n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    ok = done;
  endtask

  task automatic run_vec(input vec_t v, input int l);
    bit ok;
    @(negedge clk);
    cfg_indirect = v.ind;
    cfg_page_sel = v.psel;
    cfg_esz_log2 = v.esz;
    cfg_base     = v.base;
    lookup_idx   = v.idx;
    err_addr     = v.erra;
    lat          = l;
    nreads       = 0;
    start        = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    chk(ok, "R10 done seen", {63'd0, ok}, 64'd1);
    chk(entry == v.ent, "R5/R6/R7 entry", entry, v.ent);
    chk(entry_valid == v.ev, "R5/R6 entry_valid", {63'd0, entry_valid}, {63'd0, v.ev});
    chk(entry_err == v.ee, "R7 entry_err", {63'd0, entry_err}, {63'd0, v.ee});
    repeat (4) @(negedge clk);
    chk(nreads == int'(v.nrd), "R1/R6/R7 read count", 64'(nreads), 64'(v.nrd));
    if (v.nrd >= 1) chk(addr1 == v.a1, "R1/R2 first address", 64'(addr1), 64'(v.a1));
    if (v.nrd == 2) chk(addr2 == v.a2, "R3/R4/R8 second address", 64'(addr2), 64'(v.a2));
    chk(entry == v.ent && !done, "R10 result held", entry, v.ent);
  endtask

  initial begin
    bit ok;
    mem[52'h10028]  = 64'h8000_0000_0000_00A5;
    mem[52'h10030]  = 64'h0000_0000_0000_0033;
    mem[52'h10080]  = 64'h8000_0000_0000_0C40;
    mem[52'h10018]  = 64'h8000_0000_0004_0000;
    mem[52'h40028]  = 64'h8000_0000_0000_1234;
    mem[52'h20018]  = 64'h8000_0000_0005_0000;
    mem[52'h50030]  = 64'h8000_0000_0000_BEEF;
    mem[52'h30008]  = 64'h0000_0000_0006_0000;
    mem[52'h30010]  = 64'hFFF8_0000_0007_0000;
    mem[52'h70010]  = 64'h8000_0000_0000_0777;
    mem[52'h700A0]  = 64'h0000_0000_0000_00AA;
    mem[52'h10048]  = 64'h8000_0000_0000_0048;
    mem[52'h40140]  = 64'h8000_0000_0000_5140;
    mem[52'h20000]  = 64'h8000_0000_0008_0000;
    mem[52'h80000]  = 64'h8000_0000_0000_0001;
    mem[52'h8FFFF8] = 64'h8000_0000_00FF_FFFF;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(!busy && !mem_req && !done, "R11 control idle", {61'd0, busy, mem_req, done}, 64'd0);
    chk(entry == 64'd0 && !entry_valid && !entry_err, "R11 result cleared", entry, 64'd0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], (i % 3) + 1);

    // R9: second start and new configuration during a slow two-level walk
    @(negedge clk);
    cfg_indirect = 1'b1; cfg_page_sel = 2'd0; cfg_esz_log2 = 3'd3;
    cfg_base = 52'h10000; lookup_idx = 20'h605; err_addr = '0;
    lat = 3; nreads = 0; start = 1'b1;
    @(negedge clk);
    chk(busy, "R9 busy after start", {63'd0, busy}, 64'd1);
    cfg_indirect = 1'b0; cfg_esz_log2 = 3'd4; cfg_base = 52'h10000; lookup_idx = 20'h3;
    repeat (2) @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    chk(ok && entry == 64'h8000_0000_0000_1234, "R9 first lookup result kept", entry, 64'h8000_0000_0000_1234);
    @(negedge clk);
    chk(!done, "R10 done one cycle", {63'd0, done}, 64'd0);
    repeat (4) @(negedge clk);
    chk(nreads == 2 && addr2 == 52'h40028, "R9 no restart", 64'(nreads), 64'd2);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule